// File: doc/BRIEF.md
# Cascaded PD Timing Strobe Generator

This block derives every timing strobe that a USB Power Delivery physical layer needs from a single kernel clock. A power-of-two prescaler first makes a peripheral-rate tick. A programmable divider on that tick makes the half-bit tick. A second programmable divider, also on the peripheral tick, makes the inter-frame gap tick. A third divider counts half-bit ticks to make the transition-window tick. Every output is a one-cycle enable pulse in the kernel clock domain. None of them is a derived clock, so downstream logic stays on one clock and qualifies its registers with the strobes.

The divider fields are static configuration inputs. Each field has its own encoding. The prescaler takes a power-of-two exponent. The other three take the division ratio minus one. On the gap and window fields the code zero is reserved. A reserved setting silences the strobe it governs and sets a sticky error flag. Dropping the enable input silences all strobes in the same cycle and returns every counter to zero. After a new enable, the first strobe of each chain comes exactly one full period later.

Top module: `pd_tick_gen`

## Requirements
- R1: With prescale code c in 0..4 and enable held high, `pclk_tick` is high exactly on enabled cycles n (counted from 0 at the first enabled cycle) where (n+1) is a multiple of 2^c; code 0 makes it high on every enabled cycle.
- R2: `hbit_tick` is high exactly when (n+1) is a multiple of P*(h+1), where P is the prescale ratio and h is the 6-bit half-bit code; code 0 makes it follow `pclk_tick`, and code 63 divides by 64.
- R3: For an inter-frame gap code g in 1..31, `ifg_tick` is high exactly when (n+1) is a multiple of P*(g+1).
- R4: The transition-window divider counts half-bit ticks. For a window code t in 1..31, `twin_tick` is high exactly when (n+1) is a multiple of P*(h+1)*(t+1), and it is never high without `hbit_tick`.
- R5: A gap code of 0 keeps `ifg_tick` low, and a window code of 0 keeps `twin_tick` low. The other strobes are not affected.
- R6: Prescale codes 5, 6 and 7 are reserved. Under any of them all four strobes stay low.
- R7: `config_error` rises one cycle after any enabled cycle with a reserved code (prescale above 4, gap 0 or window 0). It then stays high until `rst_n` is asserted. It stays low while no reserved code has been enabled.
- R8: While `enable` is low, all strobes are low in that same cycle. Re-enabling restarts all counters from zero, whatever state they held before.
- R9: After reset, with `enable` low, all strobes and `config_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; low stops and clears everything |
| psc_code | input | 3 | Prescale exponent, ratio 2^code, codes 0..4 valid |
| hbit_code | input | 6 | Half-bit divider, ratio code+1 |
| ifg_code | input | 5 | Inter-frame gap divider, ratio code+1, 0 reserved |
| twin_code | input | 5 | Transition-window divider in half-bit ticks, ratio code+1, 0 reserved |
| pclk_tick | output | 1 | Peripheral-rate strobe |
| hbit_tick | output | 1 | Half-bit strobe |
| ifg_tick | output | 1 | Inter-frame gap strobe |
| twin_tick | output | 1 | Transition-window strobe |
| config_error | output | 1 | Sticky reserved-setting flag |

## Verification
Every strobe decodes combinationally from counter state and the enable input. A strobe therefore appears in the cycle in which its count completes, with no register latency along the cascade. A drop of enable shows on the strobes in that same cycle. The bench samples once per cycle, mid-cycle, after the n-th enabled rising edge. At each sample it compares all four strobes against the modulo formulas for cycle n. `config_error` is registered, so the bench checks it only after at least one enabled edge has passed under the reserved setting.

// File: rtl/pd_tick_pkg.sv
package pd_tick_pkg;
  localparam int unsigned PSC_CODE_W   = 3;
  localparam int unsigned PSC_MAX_CODE = 4;
  localparam int unsigned HBIT_CODE_W  = 6;
  localparam int unsigned IFG_CODE_W   = 5;
  localparam int unsigned TWIN_CODE_W  = 5;

  // Prescale ratio for a valid exponent code.
  function automatic int unsigned psc_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/pd_pow2_prescaler.sv
module pd_pow2_prescaler #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MAX_CODE = 4,
  localparam int unsigned CNT_W   = (MAX_CODE > 0) ? MAX_CODE : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              reserved_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  assign reserved_o = (32'(code_i) > MAX_CODE);

  always_comb begin
    if (reserved_o) limit = '0;
    else            limit = CNT_W'(pd_tick_pkg::psc_ratio(32'(code_i)) - 32'd1);
  end

  assign wrap   = (cnt_q >= limit);
  assign tick_o = en_i && !reserved_o && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!en_i || reserved_o)  cnt_q <= '0;
    else if (wrap)                 cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // R8: a disabled cycle leaves the counter at zero
  a_r8_psc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R1: the counter never runs past the programmed limit under a fixed code
  a_r1_psc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $stable(code_i) && !reserved_o) |-> (cnt_q <= limit));
  // R1: a strobe is followed by a fresh count
  a_r1_psc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/pd_tick_divider.sv
module pd_tick_divider #(
  parameter int unsigned CODE_W        = 5,
  parameter bit          ZERO_RESERVED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              parent_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              reserved_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              wrap;

  generate
    if (ZERO_RESERVED) begin : g_zero_res
      assign reserved_o = (code_i == '0);
    end else begin : g_zero_ok
      assign reserved_o = 1'b0;
    end
  endgenerate

  assign wrap   = (cnt_q >= code_i);
  assign tick_o = en_i && !reserved_o && parent_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!en_i || reserved_o) cnt_q <= '0;
    else if (parent_i) begin
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a child strobe needs a parent strobe in the same cycle
  a_r4_child_needs_parent: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> parent_i);
  // R8: the count is zero after any disabled cycle
  a_r8_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R2: the count only moves on a parent strobe
  a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !parent_i && !reserved_o) |=> $stable(cnt_q));
  // R5: a reserved code pins the count at zero
  a_r5_div_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_o |=> (cnt_q == '0));
endmodule

// File: rtl/pd_tick_gen.sv
module pd_tick_gen
  import pd_tick_pkg::*;
#(
  parameter int unsigned P_CODE_W = PSC_CODE_W,
  parameter int unsigned P_MAX    = PSC_MAX_CODE,
  parameter int unsigned H_CODE_W = HBIT_CODE_W,
  parameter int unsigned G_CODE_W = IFG_CODE_W,
  parameter int unsigned T_CODE_W = TWIN_CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [P_CODE_W-1:0] psc_code,
  input  logic [H_CODE_W-1:0] hbit_code,
  input  logic [G_CODE_W-1:0] ifg_code,
  input  logic [T_CODE_W-1:0] twin_code,
  output logic                pclk_tick,
  output logic                hbit_tick,
  output logic                ifg_tick,
  output logic                twin_tick,
  output logic                config_error
);
  logic psc_res, hbit_res, ifg_res, twin_res;
  logic any_res;
  logic err_q;

  pd_pow2_prescaler #(.CODE_W(P_CODE_W), .MAX_CODE(P_MAX)) u_psc (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .code_i(psc_code),
    .tick_o(pclk_tick), .reserved_o(psc_res));

  pd_tick_divider #(.CODE_W(H_CODE_W), .ZERO_RESERVED(1'b0)) u_hbit (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .parent_i(pclk_tick),
    .code_i(hbit_code), .tick_o(hbit_tick), .reserved_o(hbit_res));

  pd_tick_divider #(.CODE_W(G_CODE_W), .ZERO_RESERVED(1'b1)) u_ifg (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .parent_i(pclk_tick),
    .code_i(ifg_code), .tick_o(ifg_tick), .reserved_o(ifg_res));

  pd_tick_divider #(.CODE_W(T_CODE_W), .ZERO_RESERVED(1'b1)) u_twin (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .parent_i(hbit_tick),
    .code_i(twin_code), .tick_o(twin_tick), .reserved_o(twin_res));

  assign any_res = psc_res | hbit_res | ifg_res | twin_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  err_q <= 1'b0;
    else if (enable && any_res)  err_q <= 1'b1;
  end
  assign config_error = err_q;

  // R7: the error flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);
  // R7: an enabled reserved setting raises the flag
  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (psc_code > P_CODE_W'(P_MAX) || ifg_code == '0 || twin_code == '0))
      |=> config_error);
  // R6: a reserved prescale silences the whole cascade
  a_r6_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_code > P_CODE_W'(P_MAX)) |-> !(hbit_tick || ifg_tick || twin_tick));
  // R8: no strobe while disabled
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(pclk_tick || hbit_tick || ifg_tick || twin_tick));
endmodule

// File: tb/tb_pd_tick_gen.sv
module tb_pd_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] psc_code = '0;
  logic [5:0] hbit_code = '0;
  logic [4:0] ifg_code = 5'd1;
  logic [4:0] twin_code = 5'd1;
  logic pclk_tick, hbit_tick, ifg_tick, twin_tick, config_error;

  int checks = 0;
  int failures = 0;
  bit err_exp = 1'b0;

  always #10 clk = ~clk;

  pd_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .psc_code(psc_code),
    .hbit_code(hbit_code), .ifg_code(ifg_code), .twin_code(twin_code),
    .pclk_tick(pclk_tick), .hbit_tick(hbit_tick), .ifg_tick(ifg_tick),
    .twin_tick(twin_tick), .config_error(config_error));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Enable for len cycles under the given codes, checking every strobe every cycle.
  task automatic run(input int pc, input int hc, input int gc, input int tc, input int len);
    int p, h, g, t;
    bit pres;
    @(negedge clk);
    psc_code = 3'(pc); hbit_code = 6'(hc); ifg_code = 5'(gc); twin_code = 5'(tc);
    enable = 1'b1;
    pres = (pc > 4);
    p = pres ? 1 : (1 << pc);
    h = hc + 1; g = gc + 1; t = tc + 1;
    if (pres || gc == 0 || tc == 0) err_exp = 1'b1;
    #2;
    for (int n = 0; n < len; n++) begin
      int m;
      m = n + 1;
      chk(pres ? "R6" : "R1", "pclk_tick", int'(pclk_tick), int'(!pres && (m % p == 0)));
      chk(pres ? "R6" : "R2", "hbit_tick", int'(hbit_tick), int'(!pres && (m % (p*h) == 0)));
      chk((gc == 0) ? "R5" : "R3", "ifg_tick", int'(ifg_tick),
          int'(!pres && gc != 0 && (m % (p*g) == 0)));
      chk((tc == 0) ? "R5" : "R4", "twin_tick", int'(twin_tick),
          int'(!pres && tc != 0 && (m % (p*h*t) == 0)));
      @(negedge clk);
      #2;
    end
    chk("R7", "config_error", int'(config_error), int'(err_exp));
    // drop enable mid-period: strobes silent in that same cycle
    @(negedge clk);
    enable = 1'b0;
    #2;
    chk("R8", "strobes while disabled",
        int'({pclk_tick, hbit_tick, ifg_tick, twin_tick}), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    err_exp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R9", "strobes after reset",
        int'({pclk_tick, hbit_tick, ifg_tick, twin_tick}), 0);
    chk("R9", "config_error after reset", int'(config_error), 0);
  endtask

  initial begin
    #1;
    chk("R9", "strobes in reset", int'({pclk_tick, hbit_tick, ifg_tick, twin_tick}), 0);
    do_reset();
    // Sweep of valid settings; each run length leaves counters mid-period (R8 restart).
    for (int pc = 0; pc <= 4; pc++)
      for (int hi = 0; hi < 3; hi++)
        for (int gi = 0; gi < 3; gi++)
          for (int tc = 1; tc <= 2; tc++) begin
            int gc;
            gc = (gi == 0) ? 1 : (gi == 1) ? 2 : 5;
            run(pc, hi, gc, tc, 2 * (1 << pc) * (hi + 1) * (tc + 1) + 3);
          end
    // Boundary codes: half-bit 63, gap 31, gap 15, window 31
    run(0, 63, 31, 1, 2 * 64 * 2 + 3);
    run(1, 0, 15, 31, 2 * 2 * 32 + 3);
    run(0, 1, 31, 9, 2 * 2 * 10 + 3);
    // Reserved gap and window codes (R5), then sticky error (R7)
    do_reset();
    run(1, 1, 0, 2, 40);
    run(0, 2, 3, 1, 30);
    chk("R7", "config_error stays set", int'(config_error), 1);
    do_reset();
    run(2, 0, 2, 0, 40);
    do_reset();
    // Reserved prescale codes (R6)
    for (int pc = 5; pc <= 7; pc++) run(pc, 0, 1, 1, 24);
    do_reset();
    run(3, 1, 2, 1, 70);
    chk("R7", "config_error clear for valid codes", int'(config_error), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule